// File: doc/BRIEF.md
# Two-Wire Alternating-Clock Serial Receiver

This block listens to a two-line serial bus. Neither line is a fixed clock. A bit is taken on the falling edge of whichever line is the clock for that bit, and the value is read from the other line. The clock role moves from one line to the other after every bit. Packets are marked by framing patterns built from counted toggles. The receiver follows the clock role bit by bit and packs the bits into words, most significant bit first. Each finished word is presented with a one-cycle valid pulse. A one-cycle pulse also marks a correctly closed packet.

Both lines are asynchronous to the system clock. They pass through a two-flop synchronizer and are oversampled. Edges are found on the synchronized samples, so senders with different phase lengths are accepted without any setting. A silence timer discards a packet that stops without an end. The timer limit is a parameter and must be longer than the pauses a sender inserts between groups of words. Malformed framing raises a one-cycle error pulse and returns the receiver to idle. Transmission, checksums and the meaning of packet contents belong to other blocks.

The controller has four states:

- **IDLE** goes to **HEADER** when line A falls while line B is high.
- **HEADER** counts line B toggles. It goes to **BITS** when A rises after exactly the start count. It goes back to **IDLE** with an error on a wrong count or on a toggle beyond that count.
- **BITS** samples data. It goes to **TRAILER** when line B makes two edges while A is the pending clock and is high. It goes to **IDLE** with an error when a data line moves twice in any other position.
- **TRAILER** counts line A toggles. It goes to **IDLE** with `pkt_end` when B rises after exactly the end count and no word is partly filled. Otherwise it goes to **IDLE** with an error.

From any state other than IDLE, the receiver goes to **IDLE** with an error when the silence timer expires.

Top module: `twowire_rx`

## Requirements
- R1: After reset all outputs are low and the receiver is idle. Activity on line B while line A stays high produces no output and leaves the receiver able to decode a following packet.
- R2: A start is accepted when A falls with B high, B then toggles exactly four times while A is low, and A then rises. The receiver is then ready for the first bit.
- R3: A start in which B toggles fewer or more than four times before A rises gives a one-cycle `rx_error` pulse and a return to idle.
- R4: A bit is sampled on the falling edge of the current clock line, and its value is the level of the other line. Line A is the clock for the first bit, and the clock role alternates on every following bit.
- R5: Bits are shifted in MSB first. After every 32nd bit, `word_data` holds the word and `word_valid` is high for exactly one cycle.
- R6: When A is the pending clock and is high, B rising and then falling begins the end pattern. If A then toggles exactly twice and B then rises, `pkt_end` pulses for one cycle and the receiver returns to idle, provided the bit count is a whole number of words.
- R7: An end pattern that arrives after a bit count that is not a multiple of 32 gives `rx_error` and no `pkt_end`.
- R8: An end pattern in which A toggles a number of times other than two before B rises, or in which B falls, gives `rx_error`.
- R9: When no edge is seen on either line for `TIMEOUT_CYCLES` cycles outside idle, the receiver pulses `rx_error` and returns to idle. Shorter pauses, such as a pause between groups of words, do not break the packet.
- R10: Decoding does not depend on the sender's phase length, provided each phase spans several system clock cycles.
- R11: `word_valid`, `pkt_end` and `rx_error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_a | input | 1 | Bus line A, asynchronous |
| line_b | input | 1 | Bus line B, asynchronous |
| word_valid | output | 1 | One-cycle pulse when a full word is assembled |
| word_data | output | 32 | Last assembled word, MSB received first |
| pkt_end | output | 1 | One-cycle pulse on a correct end pattern |
| rx_error | output | 1 | One-cycle pulse on malformed framing or silence timeout |

## Verification
The assertions check on every cycle that the three output pulses never coincide and that a word pulse lasts one cycle. They also check that each header outcome leads to the state and error pulse it should, that the clock role flips on every sampled bit, that a partial word at the end gives an error instead of an end, and that the silence counter stays in range and forces a return to idle. Only the bench scenarios can show that real waveforms decode to the right words. These scenarios cover two phase lengths, a long pause inside a packet, an ignored idle toggle on line B, each malformed header and trailer, and recovery to a clean packet afterwards.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HEADER,
        S_BITS,
        S_TRAILER
    } rx_state_t;

    localparam int LINE_A = 0;
    localparam int LINE_B = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    logic [LINES-1:0] meta;
    logic [LINES-1:0] stable;
    logic [LINES-1:0] last;

    // Idle bus level is high, so reset the whole chain high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= '1;
            stable <= '1;
            last   <= '1;
        end else begin
            meta   <= raw;
            stable <= meta;
            last   <= stable;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_edge
        assign lvl[i]  = stable[i];
        assign rise[i] = stable[i] & ~last[i];
        assign fall[i] = ~stable[i] & last[i];
    end

endmodule

// File: rtl/twr_gap_timer.sv
module twr_gap_timer #(
    parameter int LIMIT = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || kick) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT));

    // R9: the silence counter saturates at its limit.
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));

    // R9: the count restarts after an edge or when the receiver is idle.
    a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || kick) |=> (cnt == '0));

endmodule

// File: rtl/twr_word_asm.sv
module twr_word_asm #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              partial
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (clear) begin
                shreg <= '0;
                cnt   <= '0;
            end else if (shift_en) begin
                if (cnt == LAST_IDX) begin
                    word_data  <= {shreg[WORD_W-2:0], bit_in};
                    word_valid <= 1'b1;
                    shreg      <= '0;
                    cnt        <= '0;
                end else begin
                    shreg <= {shreg[WORD_W-2:0], bit_in};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    assign partial = (cnt != '0);

    // R5: the word strobe lasts a single cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5: the last bit of a word raises the strobe and empties the counter.
    a_r5_word_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear && cnt == LAST_IDX) |=> (word_valid && cnt == '0));

endmodule

// File: rtl/twowire_rx.sv
module twowire_rx
    import twr_pkg::*;
#(
    parameter int WORD_W         = 32,
    parameter int TIMEOUT_CYCLES = 40000,
    parameter int START_TOGGLES  = 4,
    parameter int END_TOGGLES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_a,
    input  logic              line_b,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              pkt_end,
    output logic              rx_error
);

    localparam int TOG_MAX = (START_TOGGLES > END_TOGGLES) ? START_TOGGLES : END_TOGGLES;
    localparam int TOG_W   = $clog2(TOG_MAX + 1);
    localparam logic [TOG_W-1:0] START_N = TOG_W'(START_TOGGLES);
    localparam logic [TOG_W-1:0] END_N   = TOG_W'(END_TOGGLES);

    // Synchronized levels and edges
    logic [NUM_LINES-1:0] lvl, rise, fall;
    logic lvl_a, lvl_b, rise_a, rise_b, fall_a, fall_b, edge_a, edge_b, any_edge;

    twr_line_sync #(.LINES(NUM_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({line_b, line_a}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign lvl_a    = lvl[LINE_A];
    assign lvl_b    = lvl[LINE_B];
    assign rise_a   = rise[LINE_A];
    assign rise_b   = rise[LINE_B];
    assign fall_a   = fall[LINE_A];
    assign fall_b   = fall[LINE_B];
    assign edge_a   = rise_a | fall_a;
    assign edge_b   = rise_b | fall_b;
    assign any_edge = edge_a | edge_b;

    // Controller state
    rx_state_t        state, nxt_state;
    logic             sel, nxt_sel;        // 0: A is the clock, 1: B is the clock
    logic [TOG_W-1:0] tog, nxt_tog;        // toggles counted in framing patterns
    logic [1:0]       dedge, nxt_dedge;    // data line edges since last sample

    logic shift_en, shift_bit, end_ok, fault;
    logic gap_expired, partial;
    logic clk_fall, data_edge, data_lvl;

    assign clk_fall  = sel ? fall_b : fall_a;
    assign data_edge = sel ? edge_a : edge_b;
    assign data_lvl  = sel ? lvl_a  : lvl_b;

    twr_gap_timer #(.LIMIT(TIMEOUT_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state != S_IDLE),
        .kick   (any_edge),
        .expired(gap_expired)
    );

    twr_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == S_IDLE),
        .shift_en  (shift_en),
        .bit_in    (shift_bit),
        .word_valid(word_valid),
        .word_data (word_data),
        .partial   (partial)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_sel   = sel;
        nxt_tog   = tog;
        nxt_dedge = dedge;
        shift_en  = 1'b0;
        shift_bit = 1'b0;
        end_ok    = 1'b0;
        fault     = 1'b0;
        if (gap_expired) begin
            fault     = 1'b1;
            nxt_state = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (fall_a && lvl_b) begin
                        nxt_state = S_HEADER;
                        nxt_tog   = '0;
                    end
                end
                S_HEADER: begin
                    if (rise_a) begin
                        if (tog == START_N) begin
                            nxt_state = S_BITS;
                            nxt_sel   = 1'b0;
                            nxt_dedge = '0;
                        end else begin
                            fault     = 1'b1;
                            nxt_state = S_IDLE;
                        end
                    end else if (edge_b) begin
                        if (tog == START_N) begin
                            fault     = 1'b1;
                            nxt_state = S_IDLE;
                        end else begin
                            nxt_tog = tog + 1'b1;
                        end
                    end
                end
                S_BITS: begin
                    if (clk_fall) begin
                        shift_en  = 1'b1;
                        shift_bit = data_lvl;
                        nxt_sel   = ~sel;
                        nxt_dedge = '0;
                    end else if (data_edge) begin
                        if (dedge == 2'd1) begin
                            if (!sel && lvl_a) begin
                                nxt_state = S_TRAILER;
                                nxt_tog   = '0;
                            end else begin
                                fault     = 1'b1;
                                nxt_state = S_IDLE;
                            end
                        end else begin
                            nxt_dedge = dedge + 1'b1;
                        end
                    end
                end
                S_TRAILER: begin
                    if (rise_b) begin
                        if (tog == END_N && !partial) begin
                            end_ok = 1'b1;
                        end else begin
                            fault = 1'b1;
                        end
                        nxt_state = S_IDLE;
                    end else if (fall_b) begin
                        fault     = 1'b1;
                        nxt_state = S_IDLE;
                    end else if (edge_a) begin
                        if (tog == END_N) begin
                            fault     = 1'b1;
                            nxt_state = S_IDLE;
                        end else begin
                            nxt_tog = tog + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            sel   <= 1'b0;
            tog   <= '0;
            dedge <= '0;
        end else begin
            state <= nxt_state;
            sel   <= nxt_sel;
            tog   <= nxt_tog;
            dedge <= nxt_dedge;
        end
    end

    // Registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_end  <= 1'b0;
            rx_error <= 1'b0;
        end else begin
            pkt_end  <= end_ok;
            rx_error <= fault;
        end
    end

    // R11: output pulses are mutually exclusive.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_valid, pkt_end, rx_error}));

    // R2: a correct header opens the bit phase without an error.
    a_r2_header_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEADER && !gap_expired && rise_a && tog == START_N)
        |=> (state == S_BITS && !rx_error));

    // R3: a header with the wrong toggle count is rejected.
    a_r3_header_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEADER && !gap_expired && rise_a && tog != START_N)
        |=> (state == S_IDLE && rx_error));

    // R4: the clock role flips on every sampled bit.
    a_r4_role_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BITS && !gap_expired && clk_fall) |=> (sel != $past(sel)));

    // R6: an end pulse only follows the trailer state.
    a_r6_end_from_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> ($past(state) == S_TRAILER && state == S_IDLE));

    // R7: a partly filled word at the end gives an error, never an end.
    a_r7_partial_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRAILER && !gap_expired && rise_b && partial)
        |=> (rx_error && !pkt_end));

    // R9: silence past the limit aborts the packet.
    a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        gap_expired |=> (rx_error && state == S_IDLE));

endmodule

// File: tb/twowire_rx_test.sv
module twowire_rx_test;

    localparam int TMO = 30000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        la = 1'b1;
    logic        lb = 1'b1;
    logic        word_valid, pkt_end, rx_error;
    logic [31:0] word_data;

    always #2 clk = ~clk;

    twowire_rx #(
        .WORD_W(32), .TIMEOUT_CYCLES(TMO), .START_TOGGLES(4), .END_TOGGLES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_a(la), .line_b(lb),
        .word_valid(word_valid), .word_data(word_data),
        .pkt_end(pkt_end), .rx_error(rx_error)
    );

    // Expected event kinds: 0 word, 1 packet end, 2 error
    typedef struct {
        int          kind;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    bit   tx_sel = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] data, input string tag);
        exp_t e;
        e.kind = kind;
        e.data = data;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: pops expectations as the design reports events
    always @(negedge clk) begin
        int   act_k;
        exp_t e;
        if (rst_n && (word_valid || pkt_end || rx_error)) begin
            act_k = word_valid ? 0 : (pkt_end ? 1 : 2);
            check(int'(word_valid) + int'(pkt_end) + int'(rx_error) == 1,
                  "R11", "simultaneous pulses", {29'd0, word_valid, pkt_end, rx_error}, 32'd0);
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected event kind", act_k, 32'hFFFF_FFFF);
            end else begin
                e = q.pop_front();
                check(act_k == e.kind, e.tag, "event kind", act_k, e.kind);
                if (e.kind == 0)
                    check(word_data == e.data, e.tag, "word value", word_data, e.data);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start(input int p, input int toggles);
        la = 1'b0; wait_cyc(p);
        repeat (toggles) begin lb = ~lb; wait_cyc(p); end
        la = 1'b1; wait_cyc(p);
        tx_sel = 1'b0;
    endtask

    task automatic send_bit(input int p, input bit v);
        if (!tx_sel) begin
            la = 1'b1; wait_cyc(p);
            lb = v;    wait_cyc(p);
            la = 1'b0; wait_cyc(p);
        end else begin
            lb = 1'b1; wait_cyc(p);
            la = v;    wait_cyc(p);
            lb = 1'b0; wait_cyc(p);
        end
        tx_sel = ~tx_sel;
    endtask

    task automatic send_word(input int p, input logic [31:0] w, input string tag);
        push(0, w, tag);
        for (int i = 31; i >= 0; i--) send_bit(p, w[i]);
    endtask

    task automatic send_end(input int p, input int a_toggles);
        la = 1'b1; wait_cyc(p);
        lb = 1'b1; wait_cyc(p);
        lb = 1'b0; wait_cyc(p);
        repeat (a_toggles) begin la = ~la; wait_cyc(p); end
        lb = 1'b1; wait_cyc(p);
        if (!la) begin la = 1'b1; wait_cyc(p); end
    endtask

    task automatic drain(input string tag);
        wait_cyc(40);
        check(q.size() == 0, tag, "pending expectations", q.size(), 32'd0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R1: quiet outputs after reset
        check({word_valid, pkt_end, rx_error} == 3'b000, "R1", "reset outputs",
              {29'd0, word_valid, pkt_end, rx_error}, 32'd0);

        // R1: B toggling with A high is ignored
        repeat (3) begin lb = 1'b0; wait_cyc(30); lb = 1'b1; wait_cyc(30); end
        drain("R1");

        // R2 R4 R5 R6: two words at a short phase
        send_start(40, 4);
        send_word(40, 32'hA5C3_0F01, "R4");
        send_word(40, 32'h8000_0001, "R5");
        push(1, 32'd0, "R6");
        send_end(40, 2);
        drain("R2");

        // R10 R9: longer phase with an in-packet pause below the limit
        send_start(62, 4);
        send_word(62, 32'h1234_5678, "R10");
        wait_cyc(27500);
        send_word(62, 32'hFFFF_FFFF, "R9");
        send_word(62, 32'h0000_0000, "R10");
        send_word(62, 32'hDEAD_BEEF, "R10");
        push(1, 32'd0, "R6");
        send_end(62, 2);
        drain("R10");

        // R3: three toggles
        push(2, 32'd0, "R3");
        send_start(40, 3);
        lb = 1'b1; wait_cyc(40);
        drain("R3");

        // R3: five toggles
        push(2, 32'd0, "R3");
        send_start(40, 5);
        lb = 1'b1; wait_cyc(40);
        drain("R3");

        // R7: end after a half word
        send_start(40, 4);
        for (int i = 0; i < 16; i++) send_bit(40, i[0]);
        push(2, 32'd0, "R7");
        send_end(40, 2);
        drain("R7");

        // R8: end with one A toggle
        send_start(40, 4);
        send_word(40, 32'h0F0F_3C3C, "R5");
        push(2, 32'd0, "R8");
        send_end(40, 1);
        drain("R8");

        // R9: silence inside a packet
        send_start(40, 4);
        for (int i = 0; i < 10; i++) send_bit(40, 1'b1);
        push(2, 32'd0, "R9");
        wait_cyc(TMO + 60);
        la = 1'b1; lb = 1'b1; wait_cyc(40);
        drain("R9");

        // R1: recovery after errors
        send_start(40, 4);
        send_word(40, 32'h5A5A_C001, "R1");
        push(1, 32'd0, "R6");
        send_end(40, 2);
        drain("R1");

        done = 1'b1;
        finish_run();
    end

endmodule